// File: doc/BRIEF.md
# Four-Lane Lane Identity Recovery

This block works out which logical lane each of the four physical lanes of a multilane optical transport interface carries. Once per 16320-byte lane period every lane delivers its descrambled multiframe alignment byte together with a one-cycle period strobe. The two least significant bits of that byte name the lane (0 to 3). Each lane passes these bits through its own persistence filter. A value becomes the lane's identity only after it repeats over several periods in a row. The lane gives it up only after the same number of periods in a row disagree with it.

Every lane also has a loss timer with hysteresis. It declares the lane lost when the filter stays unlocked for a programmable number of clock cycles, sized for about 3 ms. It withdraws the loss only after the filter stays locked for the same number of cycles. A shared check then looks at the whole lane set. Deskew may go ahead only when all four identities differ and no lane is lost. In every other case the block reports that multilane alignment is not possible.

Top module: `lane_id_recovery`

## Requirements
- R1: The lane number is taken from bits [1:0] of the lane's byte in `mfas_in` (lane i uses bits [8i+1:8i]). The accepted number appears on `lane_id[2i+1:2i]` in the cycle after the accepting strobe.
- R2: An unlocked lane accepts a number when it sees the same value on PERSIST (default 5) consecutive strobes. A strobe that carries a different value restarts the run at 1 with that new value.
- R3: Cycles without a strobe on a lane leave that lane's state and outputs unchanged, whatever `mfas_in` carries.
- R4: A locked lane unlocks after PERSIST consecutive strobes that differ from its accepted number. A strobe that matches clears the mismatch run.
- R5: When a lane unlocks, `lane_id` keeps its last accepted number until a new one is accepted.
- R6: `lane_lor[i]` rises after lane i has been unlocked for LOSS_CYCLES consecutive clock cycles.
- R7: `lane_lor[i]` falls only after lane i has been locked for LOSS_CYCLES consecutive clock cycles. Any change of the lock state restarts the count.
- R8: After reset every lane is unlocked, `lane_lor` is all ones, `lane_id` is zero and `lanes_ok` is low.
- R9: `lanes_ok` is high only when every lane has an accepted number and no lane is lost.
- R10: `lanes_ok` is low whenever two or more lanes hold the same accepted number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_strobe | input | NUM_LANES | One-cycle lane period strobe per lane |
| mfas_in | input | 8*NUM_LANES | Descrambled multiframe byte per lane, lane i in bits [8i+7:8i] |
| lane_id | output | 2*NUM_LANES | Accepted lane number per lane |
| lane_lor | output | NUM_LANES | Per-lane loss-of-recovery flag |
| lanes_ok | output | 1 | Lane set is distinct and no lane is lost; low means out of alignment |

## Verification
The hardest situation to reach is a locked lane that loses its number while the other lanes stay healthy. To get there, the bench first brings all lanes into lock. On a single lane it then sends four mismatching periods, one matching period and four more mismatches, which shows that a broken run does not unlock the lane. A fifth mismatch then unlocks it. The bench waits out the loss timer, which is shortened through its parameter, and finally re-locks that lane onto a number another lane already holds, so the duplicate case is reached from a fully aligned set.

// File: rtl/lid_pkg.sv
package lid_pkg;
   localparam int MARK_W = 2;
   localparam int BYTE_W = 8;
   typedef logic [MARK_W-1:0] mark_t;
   typedef enum logic {ST_OOR = 1'b0, ST_IR = 1'b1} rec_state_t;
endpackage

// File: rtl/lid_lane_filter.sv
module lid_lane_filter
   import lid_pkg::*;
#(
   parameter int PERSIST = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe,
   input  mark_t      mark_in,
   output rec_state_t state_o,
   output mark_t      acc_o,
   output logic       acc_vld_o
);
   localparam int CW = $clog2(PERSIST + 1);

   if (PERSIST < 2) begin : g_bad_persist
      $error("PERSIST must be at least 2");
   end

   rec_state_t     state_q;
   mark_t          acc_q;
   mark_t          cand_q;
   logic           vld_q;
   logic [CW-1:0]  run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_OOR;
         acc_q   <= '0;
         cand_q  <= '0;
         vld_q   <= 1'b0;
         run_q   <= '0;
      end else if (strobe) begin
         case (state_q)
            ST_OOR: begin
               if (run_q != '0 && mark_in == cand_q) begin
                  if (run_q == CW'(PERSIST - 1)) begin
                     state_q <= ST_IR;
                     acc_q   <= mark_in;
                     vld_q   <= 1'b1;
                     run_q   <= '0;
                  end else begin
                     run_q <= run_q + 1'b1;
                  end
               end else begin
                  cand_q <= mark_in;
                  run_q  <= CW'(1);
               end
            end
            default: begin
               if (mark_in != acc_q) begin
                  if (run_q == CW'(PERSIST - 1)) begin
                     state_q <= ST_OOR;
                     run_q   <= '0;
                  end else begin
                     run_q <= run_q + 1'b1;
                  end
               end else begin
                  run_q <= '0;
               end
            end
         endcase
      end
   end

   assign state_o   = state_q;
   assign acc_o     = acc_q;
   assign acc_vld_o = vld_q;
endmodule

// File: rtl/lid_loss_timer.sv
module lid_loss_timer #(
   parameter int LIMIT = 375000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_rec,
   output logic lor
);
   localparam int TW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("LIMIT must be at least 1");
   end

   logic [TW-1:0] cnt_q;
   logic          lor_q;

   // Counts while the lock state disagrees with the flag; flips after LIMIT cycles.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lor_q <= 1'b1;
         cnt_q <= '0;
      end else if (in_rec == lor_q) begin
         if (cnt_q == TW'(LIMIT - 1)) begin
            lor_q <= ~lor_q;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         cnt_q <= '0;
      end
   end

   assign lor = lor_q;
endmodule

// File: rtl/lid_unique_check.sv
module lid_unique_check
   import lid_pkg::*;
#(
   parameter int NUM_LANES = 4
) (
   input  logic [NUM_LANES*MARK_W-1:0] ids,
   input  logic [NUM_LANES-1:0]        vld,
   input  logic [NUM_LANES-1:0]        lor,
   output logic                        set_ok
);
   logic [NUM_LANES-1:0][NUM_LANES-1:0] clash;

   for (genvar a = 0; a < NUM_LANES; a++) begin : g_row
      for (genvar b = 0; b < NUM_LANES; b++) begin : g_col
         if (b > a) begin : g_cmp
            assign clash[a][b] = (ids[a*MARK_W +: MARK_W] == ids[b*MARK_W +: MARK_W]);
         end else begin : g_none
            assign clash[a][b] = 1'b0;
         end
      end
   end

   assign set_ok = (&vld) && !(|lor) && !(|clash);
endmodule

// File: rtl/lane_id_recovery.sv
module lane_id_recovery
   import lid_pkg::*;
#(
   parameter int NUM_LANES   = 4,
   parameter int PERSIST     = 5,
   parameter int LOSS_CYCLES = 375000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LANES-1:0]        per_strobe,
   input  logic [NUM_LANES*8-1:0]      mfas_in,
   output logic [NUM_LANES*2-1:0]      lane_id,
   output logic [NUM_LANES-1:0]        lane_lor,
   output logic                        lanes_ok
);
   if (NUM_LANES != (1 << MARK_W)) begin : g_bad_lanes
      $error("NUM_LANES must equal the number of lane identities");
   end

   logic [NUM_LANES-1:0] vld;
   logic [NUM_LANES-1:0] unused_hi;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      rec_state_t st;

      assign unused_hi[g] = ^mfas_in[g*BYTE_W + MARK_W +: BYTE_W - MARK_W];

      lid_lane_filter #(.PERSIST(PERSIST)) u_filt (
         .clk       (clk),
         .rst_n     (rst_n),
         .strobe    (per_strobe[g]),
         .mark_in   (mfas_in[g*BYTE_W +: MARK_W]),
         .state_o   (st),
         .acc_o     (lane_id[g*MARK_W +: MARK_W]),
         .acc_vld_o (vld[g])
      );

      lid_loss_timer #(.LIMIT(LOSS_CYCLES)) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .in_rec (st == ST_IR),
         .lor    (lane_lor[g])
      );
   end

   lid_unique_check #(.NUM_LANES(NUM_LANES)) u_uniq (
      .ids    (lane_id),
      .vld    (vld),
      .lor    (lane_lor),
      .set_ok (lanes_ok)
   );
endmodule

// File: rtl/lid_checker.sv
module lid_checker #(
   parameter int NUM_LANES = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_LANES-1:0]   per_strobe,
   input logic [NUM_LANES*8-1:0] mfas_in,
   input logic [NUM_LANES*2-1:0] lane_id,
   input logic [NUM_LANES-1:0]   lane_lor,
   input logic                   lanes_ok
);
   logic past_ok;
   logic unused_bytes;
   assign unused_bytes = ^mfas_in;

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   function automatic logic ids_distinct(input logic [NUM_LANES*2-1:0] v);
      logic d = 1'b1;
      for (int a = 0; a < NUM_LANES; a++)
         for (int b = a + 1; b < NUM_LANES; b++)
            if (v[a*2 +: 2] == v[b*2 +: 2]) d = 1'b0;
      return d;
   endfunction

   AST_OK_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      lanes_ok |-> (lane_lor == '0)); // R9

   AST_OK_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      lanes_ok |-> ids_distinct(lane_id)); // R10

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_ast
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && !$past(per_strobe[g])) |-> $stable(lane_id[g*2 +: 2])); // R3

      AST_ID_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && !$stable(lane_id[g*2 +: 2])) |-> (lane_id[g*2 +: 2] == $past(mfas_in[g*8 +: 2]))); // R1
   end
endmodule

bind lane_id_recovery lid_checker #(.NUM_LANES(NUM_LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .per_strobe (per_strobe),
   .mfas_in    (mfas_in),
   .lane_id    (lane_id),
   .lane_lor   (lane_lor),
   .lanes_ok   (lanes_ok)
);

// File: tb/lane_id_recovery_tb.sv
module lane_id_recovery_tb;
   localparam int LIMIT = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  per_strobe = '0;
   logic [31:0] mfas_in = '0;
   logic [7:0]  lane_id;
   logic [3:0]  lane_lor;
   logic        lanes_ok;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lane_id_recovery #(.NUM_LANES(4), .PERSIST(5), .LOSS_CYCLES(LIMIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .per_strobe(per_strobe), .mfas_in(mfas_in),
      .lane_id(lane_id), .lane_lor(lane_lor), .lanes_ok(lanes_ok)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mk(input logic [5:0] hi, input logic [1:0] v);
      return {hi, v};
   endfunction

   task automatic period(input logic [3:0] m, input logic [1:0] v0, v1, v2, v3);
      @(negedge clk);
      per_strobe = m;
      mfas_in = {mk(6'h2b, v3), mk(6'h11, v2), mk(6'h3c, v1), mk(6'h05, v0)};
      @(negedge clk);
      per_strobe = '0;
      mfas_in = ~mfas_in;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk("R8 lor", {28'd0, lane_lor}, 32'hf);
      chk("R8 id", {24'd0, lane_id}, 32'h0);
      chk("R8 ok", {31'd0, lanes_ok}, 32'h0);
   endtask

   task automatic t_accept;
      period(4'hf, 2'd2, 2'd0, 2'd3, 2'd1);
      period(4'hf, 2'd2, 2'd0, 2'd3, 2'd1);
      period(4'hf, 2'd1, 2'd0, 2'd3, 2'd1);
      period(4'hf, 2'd2, 2'd0, 2'd3, 2'd1);
      chk("R2 four periods", {24'd0, lane_id}, 32'h0);
      period(4'hf, 2'd2, 2'd0, 2'd3, 2'd1);
      chk("R1 accepted", {24'd0, lane_id}, 32'h70);
      chk("R7 not yet cleared", {28'd0, lane_lor}, 32'hf);
      period(4'h1, 2'd2, 2'd0, 2'd0, 2'd0);
      period(4'h1, 2'd2, 2'd0, 2'd0, 2'd0);
      chk("R2 run restart", {24'd0, lane_id}, 32'h70);
      chk("R9 lane0 unaccepted", {31'd0, lanes_ok}, 32'h0);
      period(4'h1, 2'd2, 2'd0, 2'd0, 2'd0);
      chk("R1 lane0 accepted", {24'd0, lane_id}, 32'h72);
      idle(LIMIT + 3);
      chk("R7 lor cleared", {28'd0, lane_lor}, 32'h0);
      chk("R9 set ok", {31'd0, lanes_ok}, 32'h1);
   endtask

   task automatic t_idle;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         mfas_in = {8{k[3:0]}};
      end
      chk("R3 idle id", {24'd0, lane_id}, 32'h72);
      chk("R3 idle ok", {31'd0, lanes_ok}, 32'h1);
   endtask

   task automatic t_loss;
      for (int k = 0; k < 4; k++) period(4'h1, 2'd1, 2'd0, 2'd0, 2'd0);
      period(4'h1, 2'd2, 2'd0, 2'd0, 2'd0);
      for (int k = 0; k < 4; k++) period(4'h1, 2'd3, 2'd0, 2'd0, 2'd0);
      idle(LIMIT + 5);
      chk("R4 broken run keeps lock", {28'd0, lane_lor}, 32'h0);
      period(4'h1, 2'd3, 2'd0, 2'd0, 2'd0);
      chk("R5 id held", {24'd0, lane_id}, 32'h72);
      chk("R6 lor not yet", {28'd0, lane_lor}, 32'h0);
      idle(LIMIT + 3);
      chk("R6 lor set", {28'd0, lane_lor}, 32'h1);
      chk("R9 ok drops on loss", {31'd0, lanes_ok}, 32'h0);
      chk("R5 id still held", {24'd0, lane_id}, 32'h72);
   endtask

   task automatic t_dup;
      for (int k = 0; k < 5; k++) period(4'h1, 2'd1, 2'd0, 2'd0, 2'd0);
      chk("R2 relock", {24'd0, lane_id}, 32'h71);
      idle(LIMIT + 3);
      chk("R7 lor cleared again", {28'd0, lane_lor}, 32'h0);
      chk("R10 duplicate", {31'd0, lanes_ok}, 32'h0);
   endtask

   initial begin
      t_reset();
      t_accept();
      t_idle();
      t_loss();
      t_dup();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule